// File: doc/BRIEF.md
# Interval timer channel

A single down-counting timer channel meant to sit behind a register decoder. It advances only on cycles where the tick-enable input is high, which is normally a 1 MHz strobe. Software programs it through a two-word register window. The trigger word holds the channel enable, the repeat selection and a 29-bit interval value. The control word reports the live count and the interrupt status, and a write to it can clear the interrupt. An interval value N produces an expiry after N+1 ticks. A one-shot run disarms itself on expiry. A repeating run reloads the interval and keeps going.

The channel mode is held by a three-state machine. `ST_IDLE` means disarmed. `ST_ONCE` means armed for a single expiry. `ST_REPEAT` means armed and reloading. The transitions are:
- arm-once: any state to `ST_ONCE`, on a trigger write with enable set and repeat clear.
- arm-repeat: any state to `ST_REPEAT`, on a trigger write with enable and repeat both set.
- stop: any state to `ST_IDLE`, on a trigger write with enable clear.
- expire-once: `ST_ONCE` to `ST_IDLE`, on an expiry.
- expire-repeat: `ST_REPEAT` to `ST_REPEAT`, on an expiry.

Every expiry sets a sticky interrupt level.

Top module: `interval_timer`

## Requirements
- R1: After reset the interrupt is low, and both register words read as zero.
- R2: In the trigger word (`reg_sel`=0), bit 31 is enable, bit 30 is repeat and bits 28:0 are the interval. Reading it returns enable = channel armed, repeat = armed in repeat mode, bit 29 = 0, and bits 28:0 = the last written interval. Written bit 29 is ignored.
- R3: A trigger write with enable set loads the counter with interval N. The counter then falls by one on each tick-enabled cycle, and the expiry happens on the (N+1)-th such tick. Without a tick, the count holds.
- R4: A trigger write with bit 31 clear disarms the channel. After that, ticks change neither the count nor the interrupt.
- R5: In one-shot mode the expiry clears the enable bit. The count then stays at 0 and no further interrupt is raised.
- R6: In repeat mode the expiry reloads the interval and the channel keeps running, so it expires again every N+1 ticks.
- R7: The interrupt stays high until a write to the control word (`reg_sel`=1) with bit 30 set. A control write with bit 30 clear leaves it unchanged.
- R8: If an expiry and a clear write land on the same cycle, the interrupt remains high.
- R9: A trigger write on the same cycle as an expiring tick discards that expiry and loads the new interval.
- R10: The control word reads the live count in bits 28:0 and the interrupt in bit 30, with all other bits 0.
- R11: The all-ones 29-bit interval 0x1FFFFFFF loads intact and decrements to 0x1FFFFFFE on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count strobe, one cycle per timer tick |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Word select: 0 = trigger (offset 0x0), 1 = control (offset 0x4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| irq | output | 1 | Sticky interrupt level |

## Verification
On every cycle, the assertions check the following:
- the count holds without a tick and steps down by one with a tick;
- a stop write disarms the channel;
- a one-shot expiry disarms it, while a repeat expiry leaves it armed;
- the interrupt stays set until cleared, an expiry always wins, and every rise of the interrupt has an expiry behind it.

Only the bench scenarios can show the following:
- the exact N+1 tick distance;
- the reloaded value after a repeat expiry;
- a discarded expiry when a trigger write collides with it;
- the readback field layout, including the dropped bit 29 and the all-ones interval.

// File: rtl/timer_pkg.sv
package timer_pkg;
    parameter int DATA_W  = 32;
    parameter int EN_BIT  = 31;
    parameter int REP_BIT = 30;
    parameter int CLR_BIT = 30;
    parameter int IRQ_BIT = 30;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ONCE   = 2'd1,
        ST_REPEAT = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/timer_mode_fsm.sv
module timer_mode_fsm
    import timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_wr,
    input  logic wr_enable,
    input  logic wr_repeat,
    input  logic expire,
    output logic active,
    output logic repeating
);
    tmr_state_e state_q, state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (trig_wr) begin
            if (!wr_enable)     state_d = ST_IDLE;      // stop
            else if (wr_repeat) state_d = ST_REPEAT;    // arm-repeat
            else                state_d = ST_ONCE;      // arm-once
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_ONCE:   state_d = expire ? ST_IDLE : ST_ONCE;  // expire-once
                ST_REPEAT: state_d = ST_REPEAT;                   // expire-repeat
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        active    = 1'b0;
        repeating = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ONCE:   active = 1'b1;
            ST_REPEAT: begin
                active    = 1'b1;
                repeating = 1'b1;
            end
            default:   ;
        endcase
    end
endmodule

// File: rtl/timer_downcount.sv
module timer_downcount #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  logic             repeat_mode,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] reload_q,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    // step is already suppressed on a load cycle, so a colliding expiry is lost
    assign expire = step && (cnt_q == ZERO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= ZERO;
            reload_q <= ZERO;
        end else if (load) begin
            cnt_q    <= load_val;
            reload_q <= load_val;
        end else if (step) begin
            if (cnt_q != ZERO)    cnt_q <= cnt_q - ONE;
            else if (repeat_mode) cnt_q <= reload_q;
        end
    end
endmodule

// File: rtl/timer_irq_latch.sv
module timer_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic irq_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (set_evt) irq_q <= 1'b1;
        else if (clr_req) irq_q <= 1'b0;
    end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import timer_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic             trig_wr, clr_wr, step;
    logic             chan_active, chan_repeat, expire_hit;
    logic [CNT_W-1:0] cur_cnt, reload_val;
    logic             unused_wbits;

    assign trig_wr      = reg_wr && !reg_sel;
    assign clr_wr       = reg_wr && reg_sel && reg_wdata[CLR_BIT];
    assign step         = tick_en && chan_active && !trig_wr;
    assign unused_wbits = reg_wdata[CNT_W];

    timer_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_wr   (trig_wr),
        .wr_enable (reg_wdata[EN_BIT]),
        .wr_repeat (reg_wdata[REP_BIT]),
        .expire    (expire_hit),
        .active    (chan_active),
        .repeating (chan_repeat)
    );

    timer_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (trig_wr),
        .load_val    (reg_wdata[CNT_W-1:0]),
        .step        (step),
        .repeat_mode (chan_repeat),
        .cnt_q       (cur_cnt),
        .reload_q    (reload_val),
        .expire      (expire_hit)
    );

    timer_irq_latch u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (expire_hit),
        .clr_req (clr_wr),
        .irq_q   (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (!reg_sel) begin
            reg_rdata[EN_BIT]    = chan_active;
            reg_rdata[REP_BIT]   = chan_repeat;
            reg_rdata[CNT_W-1:0] = reload_val;
        end else begin
            reg_rdata[IRQ_BIT]   = irq;
            reg_rdata[CNT_W-1:0] = cur_cnt;
        end
    end
endmodule

// File: rtl/timer_chk.sv
module timer_chk
    import timer_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq,
    input logic              chan_active,
    input logic              chan_repeat,
    input logic [CNT_W-1:0]  cur_cnt,
    input logic              expire_hit
);
    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !reg_wr) |=> $stable(cur_cnt));

    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_active && tick_en && !reg_wr && cur_cnt != '0)
        |=> (cur_cnt == $past(cur_cnt) - CNT_W'(1)));

    a_r4_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && !reg_wdata[EN_BIT]) |=> !chan_active);

    a_r5_oneshot_off: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_hit && !chan_repeat && !reg_wr) |=> !chan_active);

    a_r6_repeat_on: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_hit && chan_repeat) |=> chan_active);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_wr && reg_sel && reg_wdata[CLR_BIT])) |=> irq);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        expire_hit |=> irq);

    a_r9_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(expire_hit));
endmodule

bind interval_timer timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .irq         (irq),
    .chan_active (chan_active),
    .chan_repeat (chan_repeat),
    .cur_cnt     (cur_cnt),
    .expire_hit  (expire_hit)
);

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench reference state
    bit        m_en = 0, m_per = 0, m_irq = 0;
    bit [28:0] m_rel = '0, m_cnt = '0;

    always #10 clk = ~clk;

    interval_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic [31:0] exp_trig(bit en, bit per, bit [28:0] rel);
        return {en, en & per, 1'b0, rel};
    endfunction

    function automatic [31:0] exp_ctrl(bit ir, bit [28:0] c);
        return {1'b0, ir, 1'b0, c};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(bit tk, bit wr, bit sel, logic [31:0] d);
        bit tw, ex;
        tick_en = tk; reg_wr = wr; reg_sel = sel; reg_wdata = d;
        tw = wr && !sel;
        ex = tk && m_en && !tw && (m_cnt == 0);
        if (tw) begin
            m_en = d[31]; m_per = d[30]; m_rel = d[28:0]; m_cnt = d[28:0];
        end else if (tk && m_en) begin
            if (m_cnt != 0)  m_cnt = m_cnt - 1;
            else if (m_per)  m_cnt = m_rel;
            else             m_en = 0;
        end
        if (ex) m_irq = 1;
        else if (wr && sel && d[30]) m_irq = 0;
        @(posedge clk);
        @(negedge clk);
        tick_en = 0; reg_wr = 0;
    endtask

    task automatic rd(bit sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 0);
        rd(0, v); chk("R1 trigger word", v, 0);
        rd(1, v); chk("R1 control word", v, 0);

        // R2 / R3 / R5 / R10 one-shot N=3
        cyc(0, 1, 0, 32'h8000_0003);
        rd(0, v); chk("R2 trigger readback", v, 32'h8000_0003);
        rd(1, v); chk("R10 control count", v, 32'h0000_0003);
        ticks(3);
        chk("R3 no expiry after N ticks", {31'b0, irq}, 0);
        rd(1, v); chk("R3 count at zero", v, 32'h0);
        ticks(1);
        chk("R3 expiry on tick N+1", {31'b0, irq}, 1);
        rd(0, v); chk("R5 enable self-clears", v, 32'h0000_0003);
        rd(1, v); chk("R10 irq bit in control", v, 32'h4000_0000);
        ticks(5);
        rd(1, v); chk("R5 stays idle at zero", v, 32'h4000_0000);

        // R7 clear behaviour
        cyc(0, 1, 1, 32'hBFFF_FFFF);
        chk("R7 clear bit 0 no effect", {31'b0, irq}, 1);
        cyc(0, 1, 1, 32'h4000_0000);
        chk("R7 clear bit 1 drops irq", {31'b0, irq}, 0);

        // R6 repeat N=2, R3 hold
        cyc(0, 1, 0, 32'hC000_0002);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0);
        rd(1, v); chk("R3 hold without tick", v, 32'h2);
        ticks(3);
        chk("R6 first expiry", {31'b0, irq}, 1);
        rd(1, v); chk("R6 reload after expiry", v, 32'h4000_0002);
        rd(0, v); chk("R6 still armed", v, 32'hC000_0002);
        cyc(0, 1, 1, 32'h4000_0000);
        ticks(2);
        chk("R6 no early second expiry", {31'b0, irq}, 0);
        ticks(1);
        chk("R6 second expiry", {31'b0, irq}, 1);

        // R8 expiry beats clear
        cyc(0, 1, 0, 32'hC000_0000);
        cyc(0, 1, 1, 32'h4000_0000);
        cyc(1, 1, 1, 32'h4000_0000);
        chk("R8 expiry wins over clear", {31'b0, irq}, 1);

        // R9 trigger write discards expiry
        cyc(0, 1, 1, 32'h4000_0000);
        cyc(1, 1, 0, 32'hC000_0005);
        chk("R9 expiry discarded", {31'b0, irq}, 0);
        rd(1, v); chk("R9 new interval loaded", v, 32'h5);

        // R4 stop
        cyc(0, 1, 0, 32'h4000_0007);
        rd(0, v); chk("R4 disarmed readback", v, 32'h0000_0007);
        ticks(10);
        chk("R4 no irq when stopped", {31'b0, irq}, 0);
        rd(1, v); chk("R4 count frozen", v, 32'h7);

        // R11 largest interval, R2 bit 29 dropped
        cyc(0, 1, 0, 32'h9FFF_FFFF);
        rd(0, v); chk("R11 max interval readback", v, 32'h9FFF_FFFF);
        ticks(1);
        rd(1, v); chk("R11 max interval steps down", v, 32'h1FFF_FFFE);
        cyc(0, 1, 0, 32'hA000_0005);
        rd(0, v); chk("R2 bit 29 ignored", v, 32'h8000_0005);

        // random mix against the bench reference
        for (int i = 0; i < 2000; i++) begin
            int r;
            bit tk;
            r  = int'($urandom_range(0, 99));
            tk = ($urandom_range(0, 99) < 70);
            if (r < 5)
                cyc(tk, 1, 0, {$urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                               $urandom_range(0, 1) == 1, 26'b0, 3'($urandom_range(0, 7))});
            else if (r < 10)
                cyc(tk, 1, 1, {1'b0, $urandom_range(0, 1) == 1, 30'b0});
            else
                cyc(tk, 0, 0, 0);
            rd(0, v); chk("R6 random trigger word", v, exp_trig(m_en, m_per, m_rel));
            rd(1, v); chk("R10 random control word", v, exp_ctrl(m_irq, m_cnt));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule